// File: doc/BRIEF.md
# SPI Slave with Idle-Qualified Start

This block is a byte-wide SPI slave shift engine that runs in the system clock domain. It supports all four clock polarity and phase settings. It is built so that a serial clock that is not at rest when software reset is released cannot shift the frame by one bit. The engine does not count a single serial clock edge until it has seen the clock at its rest level after the release. A transmitted byte is taken from the buffer once, at the first clock edge of a frame, so it is neither skipped nor sent twice.

On the parallel side there is a one-byte receive buffer with a ready flag that a read strobe clears. There is also a one-byte transmit buffer with a ready flag that a write clears. A sticky overrun flag reports a received byte that was replaced before it was read. A second sticky flag reports a suspected lost frame: the transmit buffer was consumed twice and no byte was received in between. Host logic drives the software-reset input to hold the engine quiet while it changes the clock settings, and pulses it to recover after a loss is reported.

Top module: `spi_guard_top`

## Requirements
- R1: The serial clock rest level is low when `cpol` is 0 and high when `cpol` is 1. After `sw_rst` falls, no serial clock edge is counted until the synchronized clock has been seen at its rest level. A clock that sits away from rest at release and then returns to rest moves neither the bit count nor the received data.
- R2: With `cpha` 0, `mosi` is sampled on the edge leaving rest and `miso` advances on the edge returning to rest. Bit 7 is on `miso` before the first edge, and data moves most significant bit first in both directions.
- R3: With `cpha` 1, `miso` advances on the edge leaving rest and `mosi` is sampled on the edge returning to rest. The first edge of a frame presents bit 7 without shifting, including when the clock was away from rest at release.
- R4: Every eighth sample loads the assembled byte into `rx_data` and sets `rx_ready`. A one-cycle `rx_rd` pulse clears `rx_ready`.
- R5: When a byte completes while `rx_ready` is still set and no `rx_rd` occurs in that cycle, `overrun` is set. It stays set until `sw_rst`.
- R6: A `tx_wr` pulse stores `tx_data` and clears `tx_ready`. The first edge of a frame commits the stored byte and sets `tx_ready`. Each written byte goes out exactly once. If no new byte was written, the previous buffer value is sent again.
- R7: If `tx_ready` rises twice with no rise of `rx_ready` in between, `frame_lost` is set. It stays set until `sw_rst`, which clears it.
- R8: While `cs_n` is high, `miso_oe` is low and the bit count and partial receive byte are cleared. A frame cut short by `cs_n` does not reach `rx_data`.
- R9: While `sw_rst` is high, `rx_ready`, `overrun` and `frame_lost` are 0, `tx_ready` is 1, and the transmit buffer, receive buffer and shift registers are zero. A `tx_wr` during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset; high holds the engine idle |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | Selects which serial clock edge samples the data |
| sclk | input | 1 | Serial clock pin |
| mosi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| rx_data | output | DW | Last received byte |
| rx_ready | output | 1 | Received byte waiting |
| rx_rd | input | 1 | Read strobe, clears `rx_ready` |
| tx_data | input | DW | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_ready | output | 1 | Transmit buffer can take a byte |
| overrun | output | 1 | Sticky: unread byte was replaced |
| frame_lost | output | 1 | Sticky: transmit consumed twice without a reception |

## Verification
The hardest case is release from software reset with chip select already low and the clock held away from rest, in both phase-1 modes. A design without the rest-level qualifier counts the return to rest as a sample edge. It then receives a byte shifted by one bit and ends the frame one edge early. A design that commits or shifts the transmit byte at the wrong edge repeats the first byte or skips to the next one, and the bench sees this because it checks every bit on `miso` at the master's sampling edge. The bench also resends a stale buffer to provoke `overrun`, cuts frames short with chip select, and forces two transmit commits with no reception in between. A design with a wrong loss counter misses `frame_lost` there, or raises it during ordinary back-to-back frames.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

    // Serial clock edge events seen in the system clock domain
    typedef struct packed {
        logic lead;   // clock leaves its rest level
        logic trail;  // clock returns to its rest level
    } sclk_evt_t;

    // Rest level of the serial clock for a given polarity setting
    function automatic logic rest_level(input logic pol);
        return pol;
    endfunction

endpackage

// File: rtl/spi_guard_sync.sv
module spi_guard_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_guard_arm.sv
module spi_guard_arm
    import spi_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_rst,
    input  logic      cpol,
    input  logic      sclk_s,
    input  logic      cs_act,
    output sclk_evt_t evt,
    output logic      armed
);
    typedef struct packed {
        logic armed;
        logic prev;
    } arm_t;

    arm_t cur_q, nxt_d;
    logic rest;

    always_comb begin
        rest        = rest_level(cpol);
        nxt_d.prev  = sclk_s;
        nxt_d.armed = sw_rst ? 1'b0 : (cur_q.armed | (sclk_s == rest));
        evt.lead    = cur_q.armed && cs_act && !sw_rst &&
                      (cur_q.prev == rest) && (sclk_s != rest);
        evt.trail   = cur_q.armed && cs_act && !sw_rst &&
                      (cur_q.prev != rest) && (sclk_s == rest);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign armed = cur_q.armed;
endmodule

// File: rtl/spi_guard_loss.sv
module spi_guard_loss (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic tx_rise,
    input  logic rx_done,
    output logic lost
);
    typedef struct packed {
        logic [1:0] cnt;
        logic       lost;
    } loss_t;

    loss_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (sw_rst) begin
            nxt_d = '0;
        end else if (rx_done) begin
            nxt_d.cnt = 2'd0;
        end else if (tx_rise) begin
            if (cur_q.cnt == 2'd1) begin
                nxt_d.lost = 1'b1;
            end
            nxt_d.cnt = (cur_q.cnt == 2'd2) ? 2'd2 : cur_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lost = cur_q.lost;
endmodule

// File: rtl/spi_guard_top.sv
module spi_guard_top
    import spi_guard_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_rst,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          sclk,
    input  logic          mosi,
    input  logic          cs_n,
    output logic          miso,
    output logic          miso_oe,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    input  logic          rx_rd,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_wr,
    output logic          tx_ready,
    output logic          overrun,
    output logic          frame_lost
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    typedef struct packed {
        logic [DW-1:0] tsh;
        logic [DW-2:0] rsh;
        logic [CW-1:0] cnt;
        logic          need;
        logic [DW-1:0] txbuf;
        logic          tx_ready;
        logic [DW-1:0] rxbuf;
        logic          rx_ready;
        logic          ovr;
    } core_t;

    logic [2:0] pins_s;
    logic       sclk_s, mosi_s, cs_act;
    sclk_evt_t  evt;
    logic       armed;
    logic       sample_e, shift_e;
    logic       rx_done, tx_rise;
    core_t      cur_q, nxt_d;

    spi_guard_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, mosi, sclk}),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign mosi_s = pins_s[1];
    assign cs_act = ~pins_s[2];

    spi_guard_arm u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .cpol   (cpol),
        .sclk_s (sclk_s),
        .cs_act (cs_act),
        .evt    (evt),
        .armed  (armed)
    );

    always_comb begin
        nxt_d    = cur_q;
        rx_done  = 1'b0;
        tx_rise  = 1'b0;
        sample_e = cpha ? evt.trail : evt.lead;
        shift_e  = cpha ? evt.lead  : evt.trail;

        if (sw_rst) begin
            nxt_d          = '0;
            nxt_d.need     = 1'b1;
            nxt_d.tx_ready = 1'b1;
        end else begin
            if (!cs_act) begin
                nxt_d.cnt  = '0;
                nxt_d.rsh  = '0;
                nxt_d.need = 1'b1;
            end else begin
                // transmit side: commit at first edge, else shift
                if (evt.lead && cur_q.need) begin
                    nxt_d.need     = 1'b0;
                    nxt_d.tx_ready = 1'b1;
                    nxt_d.tsh      = cur_q.txbuf;
                    tx_rise        = ~cur_q.tx_ready;
                end else if (shift_e && !cur_q.need) begin
                    nxt_d.tsh = {cur_q.tsh[DW-2:0], 1'b0};
                end
                // receive side
                if (sample_e) begin
                    if (cur_q.cnt == LAST_BIT) begin
                        nxt_d.cnt   = '0;
                        nxt_d.rsh   = '0;
                        nxt_d.rxbuf = {cur_q.rsh, mosi_s};
                        nxt_d.need  = 1'b1;
                        rx_done     = 1'b1;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CW'(1);
                        nxt_d.rsh = {cur_q.rsh[DW-3:0], mosi_s};
                    end
                end
            end

            // host transmit write; a write wins over a commit in the same cycle
            if (tx_wr) begin
                nxt_d.txbuf    = tx_data;
                nxt_d.tx_ready = 1'b0;
            end

            // while no byte is committed the shifter tracks the buffer
            if (nxt_d.need) begin
                nxt_d.tsh = nxt_d.txbuf;
            end

            // host receive side
            if (rx_rd) begin
                nxt_d.rx_ready = 1'b0;
            end
            if (rx_done) begin
                if (cur_q.rx_ready && !rx_rd) begin
                    nxt_d.ovr = 1'b1;
                end
                nxt_d.rx_ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.need     <= 1'b1;
            cur_q.tx_ready <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    spi_guard_loss u_loss (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .tx_rise (tx_rise),
        .rx_done (rx_done),
        .lost    (frame_lost)
    );

    assign miso     = cur_q.tsh[DW-1];
    assign miso_oe  = cs_act;
    assign rx_data  = cur_q.rxbuf;
    assign rx_ready = cur_q.rx_ready;
    assign tx_ready = cur_q.tx_ready;
    assign overrun  = cur_q.ovr;
endmodule

// File: rtl/spi_guard_chk.sv
module spi_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_rst,
    input logic cs_n,
    input logic miso_oe,
    input logic tx_wr,
    input logic tx_ready,
    input logic rx_ready,
    input logic overrun,
    input logic frame_lost,
    input logic armed
);
    p_swrst_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (tx_ready && !rx_ready && !overrun && !frame_lost));

    p_wr_clears_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !sw_rst) |=> !tx_ready);

    p_lost_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_lost && !sw_rst) |=> frame_lost);

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !sw_rst) |=> overrun);

    p_rx_needs_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(armed));

    p_oe_off_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !miso_oe);
endmodule

bind spi_guard_top spi_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .cs_n       (cs_n),
    .miso_oe    (miso_oe),
    .tx_wr      (tx_wr),
    .tx_ready   (tx_ready),
    .rx_ready   (rx_ready),
    .overrun    (overrun),
    .frame_lost (frame_lost),
    .armed      (armed)
);

// File: tb/tb_spi_guard_top.sv
module tb_spi_guard_top;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n, sw_rst, cpol, cpha, sclk, mosi, cs_n;
    logic       miso, miso_oe, rx_ready, rx_rd, tx_wr, tx_ready, overrun, frame_lost;
    logic [7:0] rx_data, tx_data;

    always #5 clk = ~clk;

    spi_guard_top dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cpol(cpol), .cpha(cpha),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_rd(rx_rd),
        .tx_data(tx_data), .tx_wr(tx_wr), .tx_ready(tx_ready),
        .overrun(overrun), .frame_lost(frame_lost)
    );

    int  vectors = 0;
    int  miscompares = 0;
    bit  busy = 1'b1;
    bit  finished = 1'b0;

    // behavioural reference state
    logic       m_rx_ready, m_tx_ready, m_ovr, m_lost, m_need;
    logic [7:0] m_rx_data, m_txbuf, m_shift, m_acc;
    int         m_rise, m_bits;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_swreset();
        m_rx_ready = 1'b0; m_tx_ready = 1'b1; m_ovr = 1'b0; m_lost = 1'b0;
        m_need = 1'b1; m_rx_data = 8'h00; m_txbuf = 8'h00; m_shift = 8'h00;
        m_acc = 8'h00; m_rise = 0; m_bits = 0;
    endtask

    task automatic m_commit();
        if (!m_tx_ready) begin
            m_rise++;
            if (m_rise >= 2) m_lost = 1'b1;
        end
        m_tx_ready = 1'b1;
        m_shift = m_txbuf;
        m_need = 1'b0;
    endtask

    task automatic m_rxdone(input logic [7:0] b);
        if (m_rx_ready) m_ovr = 1'b1;
        m_rx_ready = 1'b1;
        m_rx_data = b;
        m_rise = 0;
    endtask

    // every-clock comparison of the parallel side against the model
    always @(posedge clk) begin
        #2;
        if (!busy && !finished) begin
            chk("R4 rx_ready", 32'(rx_ready), 32'(m_rx_ready));
            chk("R4 rx_data", 32'(rx_data), 32'(m_rx_data));
            chk("R6 tx_ready", 32'(tx_ready), 32'(m_tx_ready));
            chk("R5 overrun", 32'(overrun), 32'(m_ovr));
            chk("R7 frame_lost", 32'(frame_lost), 32'(m_lost));
        end
    end

    task automatic sw_reset_pulse(input logic pol, input logic pha, input logic lvl);
        busy = 1'b1;
        @(negedge clk);
        sw_rst = 1'b1; cpol = pol; cpha = pha; sclk = lvl;
        tick(3);
        model_swreset();
        sw_rst = 1'b0;
        tick(5);
        busy = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = b;
        if (!sw_rst) begin
            m_txbuf = b; m_tx_ready = 1'b0;
        end
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        rx_rd = 1'b1; m_rx_ready = 1'b0;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic cs_low();
        busy = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        tick(H);
        busy = 1'b0;
    endtask

    task automatic cs_high();
        busy = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        m_need = 1'b1; m_bits = 0; m_acc = 8'h00;
        tick(H);
        busy = 1'b0;
    endtask

    task automatic move_sclk(input logic lvl);
        busy = 1'b1;
        @(negedge clk);
        sclk = lvl;
        tick(H);
        busy = 1'b0;
    endtask

    // master side of a frame; checks every miso bit at the master's sampling edge
    task automatic xfer(input logic [7:0] mo, input int nbits, input string tag);
        logic rest;
        logic expb;
        logic b;
        busy = 1'b1;
        rest = cpol;
        for (int k = 0; k < nbits; k++) begin
            b = mo[7-k];
            if (m_need) m_commit();
            expb = m_shift[7-m_bits];
            if (!cpha) begin
                @(negedge clk); mosi = b;
                tick(H);
                chk({tag, " miso bit"}, 32'(miso), 32'(expb));
                sclk = ~rest;
                tick(H);
                sclk = rest;
            end else begin
                @(negedge clk); sclk = ~rest; mosi = b;
                tick(H);
                chk({tag, " miso bit"}, 32'(miso), 32'(expb));
                sclk = rest;
                tick(H);
            end
            m_acc = {m_acc[6:0], b};
            m_bits++;
            if (m_bits == 8) begin
                m_rxdone(m_acc);
                m_bits = 0;
                m_need = 1'b1;
            end
        end
        tick(H);
        busy = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        cpol = 1'b0; cpha = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; tx_data = 8'h00;
        model_swreset();
        tick(3);
        rst_n = 1'b1;
        tick(3);
        busy = 1'b0;

        // R9 reset state
        chk("R9 tx_ready in sw reset", 32'(tx_ready), 32'd1);
        chk("R9 rx_ready in sw reset", 32'(rx_ready), 32'd0);
        chk("R9 flags in sw reset", 32'({overrun, frame_lost}), 32'd0);
        chk("R8 miso_oe deselected", 32'(miso_oe), 32'd0);

        // R9 write during software reset is ignored
        host_write(8'h3C);
        tick(2);
        chk("R9 write ignored tx_ready", 32'(tx_ready), 32'd1);

        // mode 0: buffer still zero from reset
        sw_reset_pulse(1'b0, 1'b0, 1'b0);
        cs_low();
        chk("R8 miso_oe selected", 32'(miso_oe), 32'd1);
        xfer(8'h66, 8, "R9 zero buffer");
        host_read();

        // R2 plain frame
        host_write(8'hA5);
        xfer(8'h5A, 8, "R2");
        chk("R4 rx_data", 32'(rx_data), 32'h5A);
        chk("R4 rx_ready set", 32'(rx_ready), 32'd1);
        host_read();
        tick(1);
        chk("R4 rx_ready cleared", 32'(rx_ready), 32'd0);

        // R6 resend of stale buffer and R5 overrun
        host_write(8'h96);
        xfer(8'h0F, 8, "R6");
        xfer(8'hF0, 8, "R6 resend");
        chk("R5 overrun set", 32'(overrun), 32'd1);
        chk("R5 last byte kept", 32'(rx_data), 32'hF0);

        // R8 partial frame discarded
        cs_high();
        chk("R8 miso_oe off", 32'(miso_oe), 32'd0);
        cs_low();
        xfer(8'hFF, 3, "R8 partial");
        cs_high();
        cs_low();
        host_read();
        xfer(8'h81, 8, "R8 after partial");
        chk("R8 rx_data aligned", 32'(rx_data), 32'h81);
        cs_high();

        sw_reset_pulse(1'b0, 1'b0, 1'b0);
        chk("R9 overrun cleared", 32'(overrun), 32'd0);

        // R7 two commits with no reception
        host_write(8'h11);
        cs_low();
        xfer(8'hAA, 3, "R7 first");
        cs_high();
        host_write(8'h22);
        cs_low();
        xfer(8'h55, 1, "R7 second");
        chk("R7 frame_lost set", 32'(frame_lost), 32'd1);
        cs_high();
        sw_reset_pulse(1'b0, 1'b0, 1'b0);
        chk("R7 frame_lost cleared", 32'(frame_lost), 32'd0);

        // R1/R3: mode 3, selected, clock away from rest at release
        busy = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        sw_reset_pulse(1'b1, 1'b1, 1'b0);
        host_write(8'hE7);
        move_sclk(1'b1);
        chk("R1 no sample from return to rest", 32'(rx_ready), 32'd0);
        xfer(8'h3B, 8, "R3 mode3");
        chk("R3 rx_data", 32'(rx_data), 32'h3B);
        host_read();
        host_write(8'h18);
        xfer(8'hC4, 8, "R3 second byte");
        chk("R3 rx_data second", 32'(rx_data), 32'hC4);
        chk("R7 no loss in normal use", 32'(frame_lost), 32'd0);
        host_read();

        // R1/R3: mode 1, clock high at release
        busy = 1'b1;
        sw_reset_pulse(1'b0, 1'b1, 1'b1);
        host_write(8'h4D);
        move_sclk(1'b0);
        chk("R1 mode1 no early sample", 32'(rx_ready), 32'd0);
        xfer(8'hB2, 8, "R3 mode1");
        chk("R3 mode1 rx_data", 32'(rx_data), 32'hB2);
        host_read();
        cs_high();

        // R2 mode 2
        sw_reset_pulse(1'b1, 1'b0, 1'b1);
        cs_low();
        host_write(8'h69);
        xfer(8'h27, 8, "R2 mode2");
        chk("R2 mode2 rx_data", 32'(rx_data), 32'h27);
        cs_high();

        tick(4);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule